// File: doc/BRIEF.md
# Card Session Status and Fault Interrupt Manager

This block drives one active-low status line for a smart card slot. The meaning of the line depends on the session command from the host. While that command is high there is no session, and the line simply shows whether a card sits in the slot. While the command is low a session is open, and the line becomes an interrupt: it drops when the card is pulled out or when any fault flag is raised. Fault flags have no effect outside a session.

When the line drops inside a session, the block sends a one-cycle start request to a deactivation sequencer, which is a separate block. The block then waits for that sequencer to report completion. It will not open another session until that report arrives. The card-presence input and the fault flags each pass through a two-stage synchronizer before any logic uses them. The session command and the completion acknowledge are taken as synchronous to the clock.

Top module: `card_irq_mgr`

## Requirements
- R1: With no session open, `stat_n` equals the synchronized card presence: 1 with a card and 0 without. A change on `card_det` reaches `stat_n` at the second rising clock edge after it is applied.
- R2: With no session open, any value on `fault_in` leaves `stat_n` unchanged.
- R3: `deact_start` is never 1 unless a session is open and `sess_n` was low on the previous cycle.
- R4: With a session open, a fault bit going to 1 or `card_det` going to 0 drives `stat_n` to 0 at the third rising edge after the input change.
- R5: `deact_start` is 1 in exactly the cycle in which `stat_n` first goes low inside the session.
- R6: `deact_start` lasts one cycle and fires at most once per session, even when further faults or a removal follow.
- R7: Once `stat_n` is low inside a session, it stays low while `sess_n` stays low, even after every fault clears. Driving `sess_n` high ends the session one edge later, and `stat_n` then shows card presence again.
- R8: A session opens (`sess_active` = 1) at the first rising edge at which `sess_n` is low and no deactivation is pending. A pending deactivation is set by `deact_start` and cleared by a one-cycle `deact_done` pulse. While it is pending, a low `sess_n` does not open a session.
- R9: After reset, no session is open, `deact_start` is 0, and `stat_n` is 0 until a card is seen through the synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sess_n | input | 1 | Session command from the host, low requests an open session |
| card_det | input | 1 | Debounced card presence, 1 when a card is inserted |
| fault_in | input | NUM_FAULTS | Fault flags (overcurrent, undervoltage and others), 1 means a fault |
| deact_done | input | 1 | Completion pulse from the deactivation sequencer |
| stat_n | output | 1 | Status and interrupt line, active low |
| deact_start | output | 1 | One-cycle request to start deactivation |
| sess_active | output | 1 | 1 while a session is open |

## Verification
The hardest case to reach is a session request that is held back: the host drives `sess_n` low again while the previous deactivation has not been acknowledged. The stimulus gets there in three steps. It trips a session with a fault, closes the session, and then asserts `sess_n` again before sending `deact_done`. The bench checks that `sess_active` stays 0 and that `stat_n` keeps following the card during the wait. It also checks that the session opens exactly two edges after the acknowledge pulse. A second case uses a fault that clears, followed by a different fault, inside one tripped session. This shows that the line stays latched low and that no second start request is issued.

// File: rtl/card_irq_mgr.sv
module card_irq_mgr #(
  parameter int NUM_FAULTS  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sess_n,
  input  logic                  card_det,
  input  logic [NUM_FAULTS-1:0] fault_in,
  input  logic                  deact_done,
  output logic                  stat_n,
  output logic                  deact_start,
  output logic                  sess_active
);
  localparam int W = NUM_FAULTS + 1;

  logic [W-1:0] sync_q [SYNC_STAGES];
  logic         card_s;
  logic [NUM_FAULTS-1:0] fault_s;
  logic         in_sess_q, tripped_q, pend_q, start_q;
  logic         trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= {card_det, fault_in};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign card_s  = sync_q[SYNC_STAGES-1][W-1];
  assign fault_s = sync_q[SYNC_STAGES-1][NUM_FAULTS-1:0];

  assign trip = in_sess_q && !sess_n && !tripped_q && (!card_s || (|fault_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_sess_q <= 1'b0;
      tripped_q <= 1'b0;
      pend_q    <= 1'b0;
      start_q   <= 1'b0;
    end else begin
      in_sess_q <= sess_n ? 1'b0 : (in_sess_q | !pend_q);
      tripped_q <= sess_n ? 1'b0 : (tripped_q | trip);
      start_q   <= trip;
      if (trip)            pend_q <= 1'b1;
      else if (deact_done) pend_q <= 1'b0;
    end
  end

  assign stat_n      = in_sess_q ? !tripped_q : card_s;
  assign deact_start = start_q;
  assign sess_active = in_sess_q;

  // R3
  a_r3_no_start_outside: assert property (@(posedge clk) disable iff (!rst_n)
    deact_start |-> (sess_active && $past(!sess_n)));
  // R5
  a_r5_start_with_low: assert property (@(posedge clk) disable iff (!rst_n)
    deact_start |-> !stat_n);
  // R6
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    deact_start |=> !deact_start);
  // R7
  a_r7_latched_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sess_active && !stat_n && !sess_n) |=> !stat_n);
  // R8
  a_r8_open_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sess_active) |-> $past(!pend_q));
endmodule

// File: tb/tb_card_irq_mgr.sv
module tb_card_irq_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sess_n = 1'b1;
  logic card_det = 1'b0;
  logic [NF-1:0] fault_in = '0;
  logic deact_done = 1'b0;
  logic stat_n, deact_start, sess_active;

  typedef struct {
    int    cyc;
    logic  stat;
    logic  start;
    logic  act;
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  card_irq_mgr #(.NUM_FAULTS(NF), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .sess_n(sess_n), .card_det(card_det),
    .fault_in(fault_in), .deact_done(deact_done),
    .stat_n(stat_n), .deact_start(deact_start), .sess_active(sess_active)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_at(input int ofs, input logic s, input logic st,
                           input logic a, input string tag);
    exp_t e;
    e.cyc = cyc + ofs; e.stat = s; e.start = st; e.act = a; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.cyc != cyc || stat_n !== e.stat || deact_start !== e.start ||
          sess_active !== e.act) begin
        fails++;
        $display("FAIL %s cyc %0d: got stat_n=%b start=%b act=%b, expected %b %b %b",
                 e.tag, cyc, stat_n, deact_start, sess_active, e.stat, e.start, e.act);
      end
    end
  end

  task automatic summary();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    expect_at(1, 0, 0, 0, "R9 reset");
    step(2);

    // R1: insert card, latency two edges
    card_det = 1'b1;
    expect_at(1, 0, 0, 0, "R1 not yet");
    expect_at(2, 1, 0, 0, "R1 present");
    step(3);

    // R2 / R3: fault outside session
    fault_in = 3'b010;
    expect_at(3, 1, 0, 0, "R2 fault masked");
    expect_at(4, 1, 0, 0, "R3 no start outside");
    step(5);
    fault_in = '0;
    step(3);

    // open session
    sess_n = 1'b0;
    expect_at(1, 1, 0, 1, "R8 open");
    step(2);

    // R4 / R5: fault in session
    fault_in = 3'b001;
    expect_at(2, 1, 0, 1, "R4 before trip");
    expect_at(3, 0, 1, 1, "R4 R5 trip");
    expect_at(4, 0, 0, 1, "R6 pulse ends");
    step(5);
    fault_in = '0;
    expect_at(4, 0, 0, 1, "R7 latched after clear");
    step(5);
    fault_in = 3'b100;
    expect_at(3, 0, 0, 1, "R6 no repeat");
    expect_at(4, 0, 0, 1, "R6 no repeat later");
    step(5);
    fault_in = '0;
    step(3);

    // close session
    sess_n = 1'b1;
    expect_at(1, 1, 0, 0, "R7 release on close");
    step(2);

    // R8: request while pending
    sess_n = 1'b0;
    expect_at(1, 1, 0, 0, "R8 held pending");
    expect_at(4, 1, 0, 0, "R8 still held");
    step(5);
    deact_done = 1'b1;
    expect_at(1, 1, 0, 0, "R8 ack edge");
    expect_at(2, 1, 0, 1, "R8 open after ack");
    step(1);
    deact_done = 1'b0;
    step(3);

    // R4: removal in session
    card_det = 1'b0;
    expect_at(2, 1, 0, 1, "R4 removal pending");
    expect_at(3, 0, 1, 1, "R4 R5 removal trip");
    expect_at(4, 0, 0, 1, "R6 removal pulse");
    step(5);

    sess_n = 1'b1;
    expect_at(1, 0, 0, 0, "R1 absent after close");
    step(2);
    deact_done = 1'b1;
    step(1);
    deact_done = 1'b0;
    step(2);
    while (q.size() > 0) step(1);
    summary();
  end
endmodule